// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block is the digital timing core of a successive-approximation analog-to-digital converter. It runs on the system clock. A programmable divider turns that clock into a slower converter clock, and a sequencer counts converter cycles to place the sample-and-hold strobe, walk through the ten bit trials and capture the finished code. The comparator, DAC and sampling capacitor sit outside the block. The comparator answers through one input bit that tells whether the trial code currently on `trialCode` is at or below the analog input.

Software-style controls drive the block: an enable, a start request, a continuous-conversion select, a divider code and a channel number. The first conversion after each enable takes a longer timeline so that the analog front end can settle. In single-shot mode the start bit drops when a conversion finishes. In continuous mode the start bit stays set and conversions follow one another with no gap.

Top module: `adcConvSequencer`

## Requirements
- R1: `prescaleSel` sets the converter clock period in system cycles: 2 for codes 0 and 1, and 2^n for codes n = 2 to 7.
- R2: While `enable` is low the divider is held cleared. Once `enable` is high, a start request takes effect at the next converter rising edge. With enable and start applied together, that edge is one full converter period after enable is first sampled high. A later start request, first sampled at edge s, launches at the first converter edge at or after s+1.
- R3: The first conversion after `enable` rises lasts 25 converter cycles, so `doneFlag` rises 26 periods after enable and start are first sampled.
- R4: Every later conversion lasts 13 converter cycles.
- R5: `sampleHold` is a one-system-cycle pulse. It comes 13.5 converter periods after the launch of a first conversion and 1.5 periods after the launch of a later one.
- R6: The bits are resolved MSB first, one per converter cycle. A trial bit is kept when `cmpKeep` is 1, so with an ideal comparator `result` equals the input code.
- R7: `result` changes only on the system cycle in which `doneFlag` is set.
- R8: In single-shot mode (`freeRun`=0) `startBit` reads 0 from the same cycle that `doneFlag` is set.
- R9: In continuous mode (`freeRun`=1) `startBit` stays 1 at completion, and the next conversion launches on the same converter edge.
- R10: `chanSel` is captured when a conversion launches and is reported on `resultChan` with that conversion's result. Later changes apply only to the following conversion.
- R11: A one-cycle `flagClr` pulse clears `doneFlag`.
- R12: Dropping `enable` aborts any conversion in progress and clears `startBit`. Start requests are ignored while the block is disabled. No strobe or completion occurs while disabled, and the next conversion after re-enabling is a first conversion again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Converter on; low holds the divider and sequencer idle |
| freeRun | input | 1 | 1 = continuous conversions, 0 = single shot |
| prescaleSel | input | 3 | Divider code for the converter clock |
| startReq | input | 1 | One-cycle request that sets the start bit |
| flagClr | input | 1 | One-cycle pulse that clears the completion flag |
| chanSel | input | 4 | Channel number to capture at launch |
| cmpKeep | input | 1 | Comparator answer: trial code is not above the input |
| startBit | output | 1 | Current state of the start bit |
| sampleHold | output | 1 | Sample-and-hold strobe |
| trialValid | output | 1 | A bit trial is being presented on trialCode |
| trialCode | output | 10 | Code driven to the DAC: decided bits plus the trial bit |
| result | output | 10 | Last completed conversion code |
| resultChan | output | 4 | Channel captured for the last completed conversion |
| doneFlag | output | 1 | Sticky completion flag |

## Verification
The hardest case to reach from the ports is the second conversion of a single-shot session. Its launch edge depends on the divider phase at the moment the start request arrives, and that phase is not visible at the ports. The bench counts every system edge from the moment enable and start are applied together. From that count it knows the divider phase exactly, so it can issue the second request after a random delay and predict the launch edge, the strobe and the completion cycle. Continuous mode, a change of channel during a conversion and an abort that is followed by a re-enable are each driven with a chosen divider code and with random targets.

// File: rtl/adcSeqPkg.sv
`timescale 1ns/1ps
package adcSeqPkg;

  // default converter resolution and channel field width
  localparam int ADC_RES = 10;
  localparam int ADC_CHAN_W = 4;

  // strobes from the sequencer to the SAR datapath
  typedef struct packed {
    logic launch;   // conversion starts: clear accumulator, capture channel
    logic trialOn;  // a bit trial is being presented
    logic decide;   // end of a trial cycle: keep or drop the trial bit
    logic commit;   // conversion finished: copy accumulator to result
  } seqStrobes_t;

endpackage

// File: rtl/adcClkDivider.sv
`timescale 1ns/1ps
module adcClkDivider #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] prescaleSel,
  output logic             riseTick,
  output logic             fallTick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] halfCnt;

  // code 0 and 1 both give a period of two system cycles
  always_comb begin
    if (prescaleSel == '0) begin
      lastCnt = CNT_W'(1);
      halfCnt = '0;
    end else begin
      lastCnt = (CNT_W'(1) << prescaleSel) - CNT_W'(1);
      halfCnt = (CNT_W'(1) << (prescaleSel - SEL_W'(1))) - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (!enable)         cnt <= '0;
    else if (cnt >= lastCnt)  cnt <= '0;
    else                      cnt <= cnt + CNT_W'(1);
  end

  assign riseTick = enable && (cnt == lastCnt);
  assign fallTick = enable && (cnt == halfCnt);
endmodule

// File: rtl/adcSeqCtrl.sv
`timescale 1ns/1ps
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int RES_BITS     = ADC_RES,
  parameter int NORM_CYCLES  = 13,
  parameter int FIRST_CYCLES = 25,
  parameter int SH_CYCLE     = 2,
  parameter int IDX_W        = $clog2(RES_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             freeRun,
  input  logic             startReq,
  input  logic             flagClr,
  input  logic             riseTick,
  input  logic             fallTick,
  output logic             startBit,
  output logic             sampleHold,
  output logic             doneFlag,
  output seqStrobes_t      strobes,
  output logic [IDX_W-1:0] bitIdx
);
  localparam int CYC_W       = $clog2(FIRST_CYCLES + 1);
  localparam int EXTRA       = FIRST_CYCLES - NORM_CYCLES;
  localparam int TRIAL_FIRST = SH_CYCLE + 1;

  logic             busy;
  logic             isFirst;
  logic             firstPending;
  logic [CYC_W-1:0] cycNum;
  logic             finish;
  logic             launch;
  logic             trialOn;
  logic             shHit;
  int               lastCyc;
  int               offset;
  int               relCyc;

  always_comb begin
    offset  = isFirst ? EXTRA : 0;
    lastCyc = NORM_CYCLES + offset;
    relCyc  = int'(cycNum) - TRIAL_FIRST - offset;
    trialOn = busy && (relCyc >= 0) && (relCyc < RES_BITS);
    finish  = busy && riseTick && (int'(cycNum) == lastCyc);
    launch  = riseTick && startBit && (!busy || (finish && freeRun));
    shHit   = busy && fallTick && (int'(cycNum) == SH_CYCLE + offset);
    bitIdx  = IDX_W'(RES_BITS - 1 - relCyc);
    strobes.launch  = launch;
    strobes.trialOn = trialOn;
    strobes.decide  = trialOn && riseTick;
    strobes.commit  = finish;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit     <= 1'b0;
      busy         <= 1'b0;
      isFirst      <= 1'b0;
      firstPending <= 1'b1;
      cycNum       <= '0;
      sampleHold   <= 1'b0;
      doneFlag     <= 1'b0;
    end else begin
      if (!enable) begin
        startBit     <= 1'b0;
        busy         <= 1'b0;
        firstPending <= 1'b1;
        cycNum       <= '0;
      end else begin
        if (finish && !freeRun) startBit <= 1'b0;
        else if (startReq)      startBit <= 1'b1;

        if (launch) begin
          busy         <= 1'b1;
          cycNum       <= CYC_W'(1);
          isFirst      <= firstPending;
          firstPending <= 1'b0;
        end else if (finish) begin
          busy <= 1'b0;
        end else if (busy && riseTick) begin
          cycNum <= cycNum + CYC_W'(1);
        end
      end
      sampleHold <= shHit;
      if (finish)       doneFlag <= 1'b1;
      else if (flagClr) doneFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/adcSarPath.sv
`timescale 1ns/1ps
module adcSarPath
  import adcSeqPkg::*;
#(
  parameter int RES_BITS = ADC_RES,
  parameter int CHAN_W   = ADC_CHAN_W,
  parameter int IDX_W    = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strobes,
  input  logic [IDX_W-1:0]    bitIdx,
  input  logic                cmpKeep,
  input  logic [CHAN_W-1:0]   chanSel,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] result,
  output logic [CHAN_W-1:0]   resultChan
);
  logic [RES_BITS-1:0] acc;
  logic [RES_BITS-1:0] trialMask;
  logic [CHAN_W-1:0]   curChan;

  always_comb begin
    trialMask = strobes.trialOn ? (RES_BITS'(1) << bitIdx) : '0;
    trialCode = acc | trialMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc        <= '0;
      curChan    <= '0;
      result     <= '0;
      resultChan <= '0;
    end else begin
      if (strobes.commit) begin
        result     <= acc;
        resultChan <= curChan;
      end
      if (strobes.launch) begin
        acc     <= '0;
        curChan <= chanSel;
      end else if (strobes.decide && cmpKeep) begin
        acc <= acc | trialMask;
      end
    end
  end
endmodule

// File: rtl/adcConvSequencer.sv
`timescale 1ns/1ps
module adcConvSequencer
  import adcSeqPkg::*;
#(
  parameter int RES_BITS     = ADC_RES,
  parameter int CHAN_W       = ADC_CHAN_W,
  parameter int SEL_W        = 3,
  parameter int NORM_CYCLES  = 13,
  parameter int FIRST_CYCLES = 25,
  parameter int SH_CYCLE     = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                freeRun,
  input  logic [SEL_W-1:0]    prescaleSel,
  input  logic                startReq,
  input  logic                flagClr,
  input  logic [CHAN_W-1:0]   chanSel,
  input  logic                cmpKeep,
  output logic                startBit,
  output logic                sampleHold,
  output logic                trialValid,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] result,
  output logic [CHAN_W-1:0]   resultChan,
  output logic                doneFlag
);
  localparam int IDX_W = $clog2(RES_BITS);

  logic             riseTick;
  logic             fallTick;
  seqStrobes_t      strobes;
  logic [IDX_W-1:0] bitIdx;

  adcClkDivider #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rstN(rstN), .enable(enable), .prescaleSel(prescaleSel),
    .riseTick(riseTick), .fallTick(fallTick)
  );

  adcSeqCtrl #(
    .RES_BITS(RES_BITS), .NORM_CYCLES(NORM_CYCLES), .FIRST_CYCLES(FIRST_CYCLES),
    .SH_CYCLE(SH_CYCLE), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .freeRun(freeRun),
    .startReq(startReq), .flagClr(flagClr), .riseTick(riseTick),
    .fallTick(fallTick), .startBit(startBit), .sampleHold(sampleHold),
    .doneFlag(doneFlag), .strobes(strobes), .bitIdx(bitIdx)
  );

  adcSarPath #(.RES_BITS(RES_BITS), .CHAN_W(CHAN_W), .IDX_W(IDX_W)) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIdx(bitIdx),
    .cmpKeep(cmpKeep), .chanSel(chanSel), .trialCode(trialCode),
    .result(result), .resultChan(resultChan)
  );

  assign trialValid = strobes.trialOn;
endmodule

// File: rtl/adcConvSequencerChk.sv
`timescale 1ns/1ps
module adcConvSequencerChk #(
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                enable,
  input logic                freeRun,
  input logic                startBit,
  input logic                sampleHold,
  input logic [RES_BITS-1:0] result,
  input logic                doneFlag
);
  AST_SH_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleHold |=> !sampleHold);  // R5

  AST_RESULT_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> doneFlag);  // R7

  AST_SINGLE_DROPS_START: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(doneFlag) && !$past(freeRun)) |-> !startBit);  // R8

  AST_FREE_KEEPS_START: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(doneFlag) && $past(freeRun)) |-> startBit);  // R9

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sampleHold);  // R12

  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !$rose(doneFlag));  // R12
endmodule

bind adcConvSequencer adcConvSequencerChk #(.RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .freeRun(freeRun),
  .startBit(startBit), .sampleHold(sampleHold), .result(result),
  .doneFlag(doneFlag)
);

// File: tb/adcConvSequencer_bench.sv
`timescale 1ns/1ps
module adcConvSequencer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       freeRun = 1'b0;
  logic [2:0] prescaleSel = 3'd0;
  logic       startReq = 1'b0;
  logic       flagClr = 1'b0;
  logic [3:0] chanSel = 4'd0;
  logic       cmpKeep;
  logic       startBit;
  logic       sampleHold;
  logic       trialValid;
  logic [9:0] trialCode;
  logic [9:0] result;
  logic [3:0] resultChan;
  logic       doneFlag;
  logic [9:0] target = 10'd0;

  int k = 0;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  // ideal comparator: keep the trial bit when the trial code is not above the input
  assign cmpKeep = (trialCode <= target);

  adcConvSequencer u_adcConvSequencer (
    .clk(clk), .rstN(rstN), .enable(enable), .freeRun(freeRun),
    .prescaleSel(prescaleSel), .startReq(startReq), .flagClr(flagClr),
    .chanSel(chanSel), .cmpKeep(cmpKeep), .startBit(startBit),
    .sampleHold(sampleHold), .trialValid(trialValid), .trialCode(trialCode),
    .result(result), .resultChan(resultChan), .doneFlag(doneFlag)
  );

  function automatic int ratioOf(input int sel);
    return (sel == 0) ? 2 : (1 << sel);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #5;
    k++;
  endtask

  task automatic waitDone(input int limit, input int chgK, input logic [3:0] chgVal,
                          output int doneK, output int shK);
    doneK = -1;
    shK = -1;
    for (int i = 0; i < limit; i++) begin
      cyc();
      if (k == chgK) chanSel = chgVal;
      if (sampleHold && shK < 0) shK = k;
      if (doneFlag) begin
        doneK = k;
        break;
      end
    end
  endtask

  task automatic runSession(input int sel, input bit fr, input logic [9:0] tgtA,
                            input logic [9:0] tgtB, input logic [3:0] chA,
                            input logic [3:0] chB);
    int r, dk, sk, d, s, m;
    r = ratioOf(sel);
    enable = 1'b0; flagClr = 1'b1;
    cyc(); cyc();
    flagClr = 1'b0;
    freeRun = fr; prescaleSel = 3'(sel); chanSel = chA; target = tgtA;
    enable = 1'b1; startReq = 1'b1; k = 0;
    cyc();
    startReq = 1'b0;
    waitDone(30 * r, 3 * r, chB, dk, sk);
    check("R1 R2 R3 first completion edge", dk, 26 * r);
    check("R5 first strobe half-edges", sk * 2, 29 * r);
    check("R6 first result", int'(result), int'(tgtA));
    check("R10 channel held at launch", int'(resultChan), int'(chA));
    if (fr) check("R9 start kept", int'(startBit), 1);
    else    check("R8 start cleared", int'(startBit), 0);
    flagClr = 1'b1;
    cyc();
    flagClr = 1'b0;
    check("R11 flag cleared", int'(doneFlag), 0);
    target = tgtB;
    if (fr) begin
      waitDone(20 * r, -1, chB, dk, sk);
      check("R4 R9 back-to-back completion edge", dk, 39 * r);
      check("R5 normal strobe half-edges", sk * 2, 55 * r);
      check("R9 start still set", int'(startBit), 1);
    end else begin
      d = int'($urandom % (3 * r));
      repeat (d) cyc();
      s = k;
      startReq = 1'b1;
      cyc();
      startReq = 1'b0;
      m = ((s + 2 + r - 1) / r) * r;
      waitDone(20 * r, -1, chB, dk, sk);
      check("R2 R4 restarted completion edge", dk, m + 13 * r);
      check("R5 normal strobe half-edges", sk * 2, 2 * m + 3 * r);
      check("R8 start cleared again", int'(startBit), 0);
    end
    check("R6 second result", int'(result), int'(tgtB));
    check("R10 new channel used", int'(resultChan), int'(chB));
  endtask

  task automatic abortSession();
    int sawDone;
    sawDone = 0;
    enable = 1'b0; flagClr = 1'b1;
    cyc();
    flagClr = 1'b0;
    freeRun = 1'b0; prescaleSel = 3'd2; target = 10'd700;
    enable = 1'b1; startReq = 1'b1;
    cyc();
    startReq = 1'b0;
    repeat (40) begin
      cyc();
      if (doneFlag) sawDone = 1;
    end
    enable = 1'b0;
    repeat (3) begin
      cyc();
      if (doneFlag || sampleHold) sawDone = 1;
    end
    check("R12 start dropped on disable", int'(startBit), 0);
    startReq = 1'b1;
    cyc();
    startReq = 1'b0;
    repeat (200) begin
      cyc();
      if (doneFlag || sampleHold) sawDone = 1;
    end
    check("R12 start ignored while disabled", int'(startBit), 0);
    check("R12 no activity after abort", sawDone, 0);
  endtask

  initial begin
    #(20 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) cyc();
    check("reset doneFlag", int'(doneFlag), 0);
    check("reset startBit", int'(startBit), 0);
    check("reset result", int'(result), 0);
    rstN = 1'b1;
    cyc();
    // directed corners: both codes that give a period of two, the slowest divider
    runSession(0, 1'b0, 10'd0, 10'd1023, 4'd3, 4'd9);
    runSession(1, 1'b1, 10'd1023, 10'd0, 4'd15, 4'd0);
    runSession(7, 1'b0, 10'd512, 10'd511, 4'd5, 4'd6);
    abortSession();
    // a first conversion again after the abort
    runSession(2, 1'b1, 10'd341, 10'd682, 4'd1, 4'd2);
    for (int i = 0; i < 8; i++) begin
      runSession(int'($urandom % 5), 1'($urandom % 2), 10'($urandom % 1024),
                 10'($urandom % 1024), 4'($urandom % 16), 4'($urandom % 16));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule